// File: doc/BRIEF.md
# Scaled-Counter Four-Channel PWM Timer

This block is a pulse-width timer with four outputs, reached through a small 32-bit register bus. A wide free-running counter is shifted right by a programmable amount. The low 16 bits of the shifted value form the scaled count. Each channel compares the scaled count with its own 16-bit compare register. A channel output is high while the scaled count is below the compare value, so the compare register sets where the low part of the period begins. Without zero-compare, a period lasts 2^(16+scale) clocks.

The counter can run continuously, or for a single period after which the hardware drops the single-run enable. In zero-compare mode the period is shortened: the counter restarts from zero once the scaled count reaches the channel 0 compare value. Each channel also has a pending flag. The flag can track its compare condition live, or, in sticky mode, latch until software clears it. Compare and counter writes take effect at once, with no wait for a period boundary.

Top module: `scaled_pwm_timer`

## Requirements
- R1: While reset is held, the configuration register, the counter, the scaled counter and all four compare registers read zero, and every PWM output is low.
- R2: The register map is: configuration at 0x00, counter at 0x08 (31 bits, bit 31 reads zero), scaled counter at 0x10 (read-only, writes ignored), and compare register i at 0x20+4*i (low 16 bits kept). Any other offset reads zero.
- R3: The configuration fields are: scale in bits 3:0, sticky in bit 8, zero-compare in bit 9, run-always in bit 12, run-once in bit 13, and the pending flag of channel i in bit 28+i. All other bits read zero.
- R4: The scaled counter equals the counter shifted right by the scale, keeping the low 16 bits.
- R5: The counter adds one on every clock while run-always or run-once is set, and holds while both are clear. A bus write to the counter loads it in that cycle and takes priority over counting.
- R6: Output i is high exactly when the scaled count is less than compare register i. A compare write affects the output from the cycle after the write. With compare 0xFFFF the output is low while the scaled count is 0xFFFF.
- R7: With zero-compare set and the counter running, the counter returns to zero on the clock after the scaled count is at or above compare register 0. At scale 0 this gives a period of compare0+1 clocks.
- R8: With run-once set, the counter stops after its next period end, and the hardware clears run-once. A period end is either a carry out of counter bit 15+scale or a zero-compare restart.
- R9: With sticky clear, pending flag i equals the previous cycle's condition that the scaled count is at or above compare register i.
- R10: With sticky set, a pending flag stays set once set, until software writes zero to it.
- R11: A write to the configuration register loads the pending flags from the written bits 31:28 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pwm_out | output | 4 | Channel outputs |
| irq_pend | output | 4 | Per-channel pending flags |

## Verification
The hardest situation to reach is the end of a single-run period. At scale 0 a natural period is 65536 clocks, and at higher scales it is far longer. The stimulus therefore stops the counter, loads it a few counts before the carry out of bit 15+scale, and then sets run-once. This checks the wrap at scale 0 and at scale 2 within a few dozen cycles. It also starts a zero-compare single run from zero, which checks the other way a period can end.

// File: rtl/scaled_pwm_pkg.sv
// Package: register offsets and configuration field positions shared by
// the PWM timer modules. Assumes byte addressing with 32-bit registers.
package scaled_pwm_pkg;

    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;

    localparam logic [ADDR_W-1:0] OFF_CFG    = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_COUNT  = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_SCALED = 8'h10;
    localparam int                CMP_BASE   = 32'h20;
    localparam int                CMP_STRIDE = 4;

    localparam int BIT_STICKY = 8;
    localparam int BIT_ZCMP   = 9;
    localparam int BIT_ALWAYS = 12;
    localparam int BIT_ONCE   = 13;
    localparam int IP_LSB     = 28;

    typedef struct packed {
        logic [3:0] scale;
        logic       sticky;
        logic       zero_cmp;
        logic       run_always;
        logic       run_once;
    } pwm_cfg_t;

endpackage

// File: rtl/spt_counter.sv
// Counter core: holds the wide counter, advances it while running, restarts
// it on a zero-compare hit, and flags the end of each period.
// Assumes CMP_W + 2**SCALE_W - 1 <= CNT_W.
module spt_counter #(
    parameter int CNT_W   = 31,
    parameter int CMP_W   = 16,
    parameter int SCALE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [SCALE_W-1:0] scale,
    input  logic               zc_hit,
    input  logic               wr_en,
    input  logic [CNT_W-1:0]   wr_val,
    output logic [CNT_W-1:0]   cnt,
    output logic [CMP_W-1:0]   scaled,
    output logic               period_end
);

    localparam int SH_W = $clog2(CMP_W + (2 ** SCALE_W));

    logic [SH_W-1:0]  wrap_bit;
    logic [CNT_W-1:0] low_mask;
    logic             carry_out;

    // Purpose: form the scaled count and detect a carry out of bit 15+scale.
    always_comb begin
        scaled    = CMP_W'(cnt >> scale);
        wrap_bit  = SH_W'(CMP_W) + SH_W'(scale);
        low_mask  = ~({CNT_W{1'b1}} << wrap_bit);
        carry_out = ((cnt & low_mask) == low_mask);
        period_end = run && !wr_en && (zc_hit || carry_out);
    end

    // Purpose: counter register; a bus load wins over counting and restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (wr_en) begin
            cnt <= wr_val;
        end else if (run) begin
            if (zc_hit) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_en) |=> $stable(cnt));

    assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wr_en && !zc_hit) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    assert_zero_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wr_en && zc_hit) |=> (cnt == '0));

endmodule

// File: rtl/spt_channel.sv
// One channel: drives the PWM output from the scaled-count comparison and
// keeps the pending flag, live or sticky. Assumes the compare value is
// already registered.
module spt_channel #(
    parameter int CMP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CMP_W-1:0] scaled,
    input  logic [CMP_W-1:0] cmp,
    input  logic             sticky,
    input  logic             ip_wr,
    input  logic             ip_wdata,
    output logic             pwm,
    output logic             ip
);

    logic reached;

    // Purpose: output high below the compare value, condition at or above it.
    always_comb begin
        pwm     = (scaled < cmp);
        reached = (scaled >= cmp);
    end

    // Purpose: pending flag; a bus write wins, otherwise it latches or tracks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ip <= 1'b0;
        end else if (ip_wr) begin
            ip <= ip_wdata;
        end else if (sticky) begin
            ip <= ip | reached;
        end else begin
            ip <= reached;
        end
    end

    assert_top_step_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (scaled == {CMP_W{1'b1}}) |-> !pwm);

    assert_sticky_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky && ip && !ip_wr) |=> ip);

    assert_live_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sticky && !ip_wr) |=> (ip == $past(reached)));

    assert_write_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ip_wr |=> (ip == $past(ip_wdata)));

endmodule

// File: rtl/spt_regs.sv
// Register file: decodes the bus, holds the configuration and compare
// registers, clears run-once at a period end, and builds the read word.
// Assumes NUM_CH <= 4 so the pending flags fit in bits 31:28.
module spt_regs
    import scaled_pwm_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int CNT_W   = 31,
    parameter int CMP_W   = 16,
    parameter int SCALE_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_en,
    input  logic                         bus_we,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic [DATA_W-1:0]            bus_rdata,
    input  logic [CNT_W-1:0]             cnt,
    input  logic [CMP_W-1:0]             scaled,
    input  logic                         period_end,
    input  logic [NUM_CH-1:0]            ip,
    output pwm_cfg_t                     cfg,
    output logic [NUM_CH-1:0][CMP_W-1:0] cmp,
    output logic                         cnt_wr,
    output logic [CNT_W-1:0]             cnt_wval,
    output logic                         ip_wr,
    output logic [NUM_CH-1:0]            ip_wdata
);

    logic              wr;
    logic              cfg_wr;
    logic [NUM_CH-1:0] cmp_wr;

    // Purpose: decode write strobes for each register.
    always_comb begin
        wr       = bus_en && bus_we;
        cfg_wr   = wr && (bus_addr == OFF_CFG);
        cnt_wr   = wr && (bus_addr == OFF_COUNT);
        cnt_wval = bus_wdata[CNT_W-1:0];
        ip_wr    = cfg_wr;
        ip_wdata = bus_wdata[IP_LSB +: NUM_CH];
        for (int i = 0; i < NUM_CH; i++) begin
            cmp_wr[i] = wr && (bus_addr == ADDR_W'(CMP_BASE + CMP_STRIDE * i));
        end
    end

    // Purpose: configuration register with hardware clear of run-once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (cfg_wr) begin
            cfg.scale      <= bus_wdata[SCALE_W-1:0];
            cfg.sticky     <= bus_wdata[BIT_STICKY];
            cfg.zero_cmp   <= bus_wdata[BIT_ZCMP];
            cfg.run_always <= bus_wdata[BIT_ALWAYS];
            cfg.run_once   <= bus_wdata[BIT_ONCE];
        end else if (period_end && cfg.run_once) begin
            cfg.run_once <= 1'b0;
        end
    end

    // Purpose: one compare register per channel, loaded straight from the bus.
    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cmp[g] <= '0;
                end else if (cmp_wr[g]) begin
                    cmp[g] <= bus_wdata[CMP_W-1:0];
                end
            end
        end
    endgenerate

    // Purpose: combinational read multiplexer; unmapped offsets return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFF_CFG) begin
            bus_rdata[SCALE_W-1:0]        = cfg.scale;
            bus_rdata[BIT_STICKY]         = cfg.sticky;
            bus_rdata[BIT_ZCMP]           = cfg.zero_cmp;
            bus_rdata[BIT_ALWAYS]         = cfg.run_always;
            bus_rdata[BIT_ONCE]           = cfg.run_once;
            bus_rdata[IP_LSB +: NUM_CH]   = ip;
        end else if (bus_addr == OFF_COUNT) begin
            bus_rdata = DATA_W'(cnt);
        end else if (bus_addr == OFF_SCALED) begin
            bus_rdata = DATA_W'(scaled);
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (bus_addr == ADDR_W'(CMP_BASE + CMP_STRIDE * i)) begin
                    bus_rdata = DATA_W'(cmp[i]);
                end
            end
        end
    end

    assert_once_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (period_end && cfg.run_once && !cfg_wr) |=> !cfg.run_once);

    assert_cfg_only_by_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> ($stable(cfg.scale) && $stable(cfg.sticky) && $stable(cfg.zero_cmp)));

endmodule

// File: rtl/scaled_pwm_timer.sv
// Top: four-channel PWM timer. It wires the register file, the counter core
// and one channel per output, and forms the zero-compare hit from channel 0.
// Assumes a single clock domain and a synchronous active-low reset.
module scaled_pwm_timer
    import scaled_pwm_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int CNT_W   = 31,
    parameter int CMP_W   = 16,
    parameter int SCALE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] pwm_out,
    output logic [NUM_CH-1:0] irq_pend
);

    pwm_cfg_t                     cfg;
    logic [NUM_CH-1:0][CMP_W-1:0] cmp;
    logic [CNT_W-1:0]             cnt;
    logic [CMP_W-1:0]             scaled;
    logic                         period_end;
    logic                         cnt_wr;
    logic [CNT_W-1:0]             cnt_wval;
    logic                         ip_wr;
    logic [NUM_CH-1:0]            ip_wdata;
    logic                         run;
    logic                         zc_hit;

    // Purpose: run enable and zero-compare restart condition.
    always_comb begin
        run    = cfg.run_always || cfg.run_once;
        zc_hit = cfg.zero_cmp && (scaled >= cmp[0]);
    end

    spt_regs #(
        .NUM_CH  (NUM_CH),
        .CNT_W   (CNT_W),
        .CMP_W   (CMP_W),
        .SCALE_W (SCALE_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_en     (bus_en),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .cnt        (cnt),
        .scaled     (scaled),
        .period_end (period_end),
        .ip         (irq_pend),
        .cfg        (cfg),
        .cmp        (cmp),
        .cnt_wr     (cnt_wr),
        .cnt_wval   (cnt_wval),
        .ip_wr      (ip_wr),
        .ip_wdata   (ip_wdata)
    );

    spt_counter #(
        .CNT_W   (CNT_W),
        .CMP_W   (CMP_W),
        .SCALE_W (SCALE_W)
    ) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .scale      (cfg.scale),
        .zc_hit     (zc_hit),
        .wr_en      (cnt_wr),
        .wr_val     (cnt_wval),
        .cnt        (cnt),
        .scaled     (scaled),
        .period_end (period_end)
    );

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            spt_channel #(
                .CMP_W (CMP_W)
            ) u_ch (
                .clk      (clk),
                .rst_n    (rst_n),
                .scaled   (scaled),
                .cmp      (cmp[g]),
                .sticky   (cfg.sticky),
                .ip_wr    (ip_wr),
                .ip_wdata (ip_wdata[g]),
                .pwm      (pwm_out[g]),
                .ip       (irq_pend[g])
            );
        end
    endgenerate

    assert_stopped_scaled_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr && !ip_wr) |=> $stable(scaled));

endmodule

// File: tb/scaled_pwm_timer_bench.sv
`timescale 1ns/1ps
module scaled_pwm_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;
    logic [3:0]  irq_pend;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    scaled_pwm_timer u_scaled_pwm_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out),
        .irq_pend  (irq_pend)
    );

    function automatic logic [15:0] model_scaled(logic [30:0] c, logic [3:0] s);
        logic [30:0] t;
        t = c >> s;
        return t[15:0];
    endfunction

    function automatic logic model_out(logic [15:0] sc, logic [15:0] cm);
        return sc < cm;
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_en = 1'b1; bus_we = 1'b0;
        #0.5;
        d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic expect_reg(logic [7:0] a, logic [31:0] exp, string tag);
        logic [31:0] v;
        bus_read(a, v);
        check(v == exp, tag, v, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, a, b, c;
        int unsigned seed_init;
        seed_init = $urandom(32'h5EED_0042);

        // R1: reset state, read while reset is held
        wait_cyc(3);
        expect_reg(8'h00, 32'h0, "R1 cfg");
        expect_reg(8'h08, 32'h0, "R1 count");
        expect_reg(8'h10, 32'h0, "R1 scaled");
        for (int i = 0; i < 4; i++) expect_reg(8'(8'h20 + 4 * i), 32'h0, "R1 cmp");
        check(pwm_out == 4'h0, "R1 pwm", 32'(pwm_out), 32'h0);
        rst_n = 1'b1;
        wait_cyc(1);

        // R3: field layout, unused bits read zero
        bus_write(8'h00, 32'hFFFF_FFFF);
        expect_reg(8'h00, 32'hF000_330F, "R3 cfg fields");
        bus_write(8'h00, 32'h0);

        // R2: register map
        bus_write(8'h08, 32'hFFFF_FFFF);
        expect_reg(8'h08, 32'h7FFF_FFFF, "R2 count width");
        bus_write(8'h10, 32'h0000_1234);
        expect_reg(8'h10, 32'h0000_FFFF, "R2 scaled read-only");
        expect_reg(8'h04, 32'h0, "R2 unmapped");
        bus_write(8'h2C, 32'hABCD_1234);
        expect_reg(8'h2C, 32'h0000_1234, "R2 cmp3 width");

        // R4 R6 R9: random stopped states, live pending
        for (int it = 0; it < 40; it++) begin
            logic [15:0] cm [4];
            logic [30:0] cv;
            logic [3:0]  sc;
            logic [15:0] es;
            for (int i = 0; i < 4; i++) begin
                int unsigned r;
                r = $urandom % 8;
                cm[i] = (r == 0) ? 16'h0 : (r == 1) ? 16'hFFFF : 16'($urandom);
                bus_write(8'(8'h20 + 4 * i), 32'(cm[i]));
            end
            cv = 31'($urandom);
            sc = 4'($urandom % 6);
            es = model_scaled(cv, sc);
            if ($urandom % 2 == 0) begin
                cm[1] = es;
                bus_write(8'h24, 32'(es));
            end
            bus_write(8'h08, 32'(cv));
            bus_write(8'h00, 32'(sc));
            wait_cyc(1);
            expect_reg(8'h10, 32'(es), "R4 scaled");
            for (int i = 0; i < 4; i++) begin
                check(pwm_out[i] == model_out(es, cm[i]), "R6 random pwm",
                      32'(pwm_out[i]), 32'(model_out(es, cm[i])));
                check(irq_pend[i] == (es >= cm[i]), "R9 live pending",
                      32'(irq_pend[i]), 32'(es >= cm[i]));
            end
        end

        // R6: compare change takes effect at once, top step always low
        bus_write(8'h00, 32'h0);
        bus_write(8'h08, 32'd100);
        bus_write(8'h24, 32'd50);
        check(pwm_out[1] == 1'b0, "R6 below", 32'(pwm_out[1]), 32'h0);
        bus_write(8'h24, 32'd200);
        check(pwm_out[1] == 1'b1, "R6 immediate", 32'(pwm_out[1]), 32'h1);
        bus_write(8'h28, 32'hFFFF);
        bus_write(8'h08, 32'hFFFF);
        check(pwm_out[2] == 1'b0, "R6 max cmp low at top", 32'(pwm_out[2]), 32'h0);
        bus_write(8'h08, 32'hFFFE);
        check(pwm_out[2] == 1'b1, "R6 max cmp high below top", 32'(pwm_out[2]), 32'h1);

        // R5: run, hold, load while running
        bus_write(8'h08, 32'd1000);
        bus_write(8'h20, 32'h0);
        bus_write(8'h00, 32'h1000);
        bus_read(8'h08, a);
        wait_cyc(7);
        bus_read(8'h08, b);
        check(b == a + 7, "R5 counting", b, a + 7);
        bus_write(8'h08, 32'h55);
        expect_reg(8'h08, 32'h55, "R5 load wins");
        bus_write(8'h00, 32'h0);
        bus_read(8'h08, a);
        wait_cyc(5);
        bus_read(8'h08, b);
        check(b == a, "R5 hold", b, a);

        // R7: zero-compare period of cmp0+1 at scale 0
        bus_write(8'h08, 32'h0);
        bus_write(8'h20, 32'd9);
        bus_write(8'h00, 32'h1200);
        wait_cyc(3);
        bus_read(8'h08, a);
        check(a <= 9, "R7 range", a, 32'd9);
        wait_cyc(10);
        bus_read(8'h08, b);
        check(b == a, "R7 period", b, a);
        wait_cyc(3);
        bus_read(8'h08, c);
        check(c == (a + 3) % 10, "R7 wrap", c, (a + 3) % 10);

        // R8: single run ends at the carry out of bit 15+scale
        bus_write(8'h00, 32'h0);
        bus_write(8'h20, 32'h0);
        bus_write(8'h08, 32'hFFF0);
        bus_write(8'h00, 32'h2000);
        wait_cyc(40);
        expect_reg(8'h08, 32'h1_0000, "R8 stop scale0");
        bus_read(8'h00, v);
        check(v[13] == 1'b0, "R8 once cleared scale0", 32'(v[13]), 32'h0);
        bus_write(8'h00, 32'h0);
        bus_write(8'h08, 32'h3_FFF0);
        bus_write(8'h00, 32'h2002);
        wait_cyc(40);
        expect_reg(8'h08, 32'h4_0000, "R8 stop scale2");
        bus_write(8'h00, 32'h0);
        bus_write(8'h08, 32'h0);
        bus_write(8'h20, 32'd5);
        bus_write(8'h00, 32'h2200);
        wait_cyc(20);
        expect_reg(8'h08, 32'h0, "R8 stop zero-compare");
        bus_read(8'h00, v);
        check(v[13] == 1'b0, "R8 once cleared zero-compare", 32'(v[13]), 32'h0);

        // R10 R11: sticky pending and bus load of pending bits
        bus_write(8'h00, 32'h0);
        bus_write(8'h08, 32'd100);
        bus_write(8'h28, 32'd50);
        bus_write(8'h00, 32'h0100);
        wait_cyc(1);
        check(irq_pend[2] == 1'b1, "R10 set", 32'(irq_pend[2]), 32'h1);
        bus_write(8'h08, 32'd10);
        wait_cyc(2);
        check(irq_pend[2] == 1'b1, "R10 held", 32'(irq_pend[2]), 32'h1);
        bus_write(8'h00, 32'h0100);
        check(irq_pend[2] == 1'b0, "R11 clear by write", 32'(irq_pend[2]), 32'h0);
        wait_cyc(2);
        check(irq_pend[2] == 1'b0, "R10 stays clear", 32'(irq_pend[2]), 32'h0);
        bus_write(8'h00, 32'h5000_0100);
        bus_read(8'h00, v);
        check(v[31:28] == 4'h5, "R11 load pattern", 32'(v[31:28]), 32'h5);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule